// File: doc/BRIEF.md
# Cascadable Eight-Way Priority Encoder

This block takes eight active-high request lines and reports the position of the most important one as a 3-bit index, plus a flag that says whether any request is present. Line 7 is the most important and line 0 the least. Inside, the eight lines are split into two groups of four. Each group is handled by a small 4-to-2 encoder slice that has its own enable input and enable output. The slices form an enable chain, so the lower group is silenced whenever the upper group holds a request. The merge stage then forms the index by OR-combining the slice codes.

The unit also has an active-low chain enable input and an active-low chain enable output, so several eight-way units can be lined up in order of importance. The chain output goes low only when this unit is enabled and sees no request. That low level hands permission to the next, less important unit. The block is purely combinational and has no clock or reset.

Top module: `cascade_prio8`

## Requirements
- R1: While enabled (`chain_en_n_i` = 0) with at least one request, `idx_o` equals the highest set bit position of `req_i`.
- R2: While enabled, `idx_o[2]` is 1 exactly when any of `req_i[7:4]` is set, so the upper group always has precedence over the lower group.
- R3: While enabled, `valid_o` is 1 exactly when `req_i` is nonzero.
- R4: While enabled with `req_i` = 0, `idx_o` is 000 and `valid_o` is 0.
- R5: While enabled with only `req_i[5]` set, `idx_o` is 101 and `valid_o` is 1.
- R6: With `chain_en_n_i` = 1, `idx_o` is 000, `valid_o` is 0 and `chain_en_n_o` is 1, for any `req_i`.
- R7: `chain_en_n_o` is 0 exactly when `chain_en_n_i` = 0 and `req_i` = 0; otherwise it is 1.
- R8: While any of `req_i[7:4]` is set, changing `req_i[3:0]` does not change `idx_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_i | input | 8 | Active-high request lines; bit 7 has the highest priority |
| chain_en_n_i | input | 1 | Active-low enable from the previous, more important unit |
| idx_o | output | 3 | Index of the winning request |
| valid_o | output | 1 | High when the enabled unit sees at least one request |
| chain_en_n_o | output | 1 | Active-low enable for the next, less important unit |

## Verification
The assertions assume the inputs are settled, two-valued levels when the combinational checks evaluate. They do not cover intermediate values during an input change. For that reason the bench changes `req_i` and `chain_en_n_i` only just after a rising edge of its own pacing clock, and it samples the outputs at the falling edge. The stimulus applies every one of the 256 request patterns with the chain enabled and again with it disabled. It then runs a sweep in which the upper group is held busy while the lower group changes, which covers the masking case directly.

// File: rtl/cascade_prio8_pkg.sv
package cascade_prio8_pkg;
    // Width of one encoder slice and of its code; the slice equations are
    // written for exactly four lines.
    localparam int SLICE_W      = 4;
    localparam int SLICE_CODE_W = 2;

    typedef struct packed {
        logic [SLICE_CODE_W-1:0] code;
        logic                    vld;
        logic                    eo;
    } slice_res_t;
endpackage

// File: rtl/prio_slice4.sv
module prio_slice4
    import cascade_prio8_pkg::*;
(
    input  logic [SLICE_W-1:0]      lines_i,
    input  logic                    en_i,
    output logic [SLICE_CODE_W-1:0] code_o,
    output logic                    vld_o,
    output logic                    eo_o
);
    slice_res_t res_d;
    logic       any_line;

    always_comb begin
        any_line       = |lines_i;
        res_d.code[1]  = en_i & (lines_i[3] | lines_i[2]);
        res_d.code[0]  = en_i & (lines_i[3] | (lines_i[1] & ~lines_i[2]));
        res_d.vld      = en_i & any_line;
        // Pass permission downward only when enabled and idle.
        res_d.eo       = en_i & ~any_line;
    end

    assign code_o = res_d.code;
    assign vld_o  = res_d.vld;
    assign eo_o   = res_d.eo;

    always_comb begin
        if (!$isunknown({lines_i, en_i})) begin
            // R7
            slice_eo_excl_chk: assert (!(eo_o && vld_o));
        end
    end
endmodule

// File: rtl/prio_merge.sv
module prio_merge
    import cascade_prio8_pkg::*;
#(
    parameter int NUM_SLICES = 2,
    localparam int SEL_W     = $clog2(NUM_SLICES),
    localparam int IDX_W     = SEL_W + SLICE_CODE_W
) (
    input  logic [NUM_SLICES-1:0][SLICE_CODE_W-1:0] codes_i,
    input  logic [NUM_SLICES-1:0]                   vlds_i,
    output logic [IDX_W-1:0]                        idx_o,
    output logic                                    vld_o
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             vld;
    } merge_t;

    merge_t res_d;

    always_comb begin
        res_d = '0;
        for (int s = 0; s < NUM_SLICES; s++) begin
            // Disabled slices drive zero, so plain OR merges are safe.
            if (vlds_i[s]) begin
                res_d.idx[IDX_W-1:SLICE_CODE_W] = res_d.idx[IDX_W-1:SLICE_CODE_W] | SEL_W'(s);
            end
            res_d.idx[SLICE_CODE_W-1:0] = res_d.idx[SLICE_CODE_W-1:0] | codes_i[s];
            res_d.vld = res_d.vld | vlds_i[s];
        end
    end

    assign idx_o = res_d.idx;
    assign vld_o = res_d.vld;

    always_comb begin
        if (!$isunknown({codes_i, vlds_i})) begin
            // R2
            one_slice_chk: assert ($onehot0(vlds_i));
        end
    end
endmodule

// File: rtl/cascade_prio8.sv
module cascade_prio8
    import cascade_prio8_pkg::*;
#(
    parameter int NUM_SLICES = 2,
    localparam int REQ_W     = NUM_SLICES * SLICE_W,
    localparam int IDX_W     = $clog2(NUM_SLICES) + SLICE_CODE_W
) (
    input  logic [REQ_W-1:0] req_i,
    input  logic             chain_en_n_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             valid_o,
    output logic             chain_en_n_o
);
    logic [NUM_SLICES-1:0]                   slice_en;
    logic [NUM_SLICES-1:0]                   slice_eo;
    logic [NUM_SLICES-1:0]                   slice_vld;
    logic [NUM_SLICES-1:0][SLICE_CODE_W-1:0] slice_code;

    // The most important slice takes the unit enable; each lower slice
    // takes the enable output of the slice just above it.
    assign slice_en[NUM_SLICES-1] = ~chain_en_n_i;

    for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
        if (g > 0) begin : g_link
            assign slice_en[g-1] = slice_eo[g];
        end
        prio_slice4 u_slice (
            .lines_i (req_i[g*SLICE_W +: SLICE_W]),
            .en_i    (slice_en[g]),
            .code_o  (slice_code[g]),
            .vld_o   (slice_vld[g]),
            .eo_o    (slice_eo[g])
        );
    end

    prio_merge #(.NUM_SLICES(NUM_SLICES)) u_merge (
        .codes_i (slice_code),
        .vlds_i  (slice_vld),
        .idx_o   (idx_o),
        .vld_o   (valid_o)
    );

    assign chain_en_n_o = ~slice_eo[0];

    always_comb begin
        if (!$isunknown({req_i, chain_en_n_i})) begin
            if (valid_o) begin
                // R1
                idx_hit_chk: assert (req_i[idx_o]);
                // R1
                idx_highest_chk: assert (((req_i >> idx_o) >> 1) == '0);
            end
            // R6
            off_quiet_chk: assert (!(chain_en_n_i && (valid_o || !chain_en_n_o)));
            // R7
            pass_down_chk: assert (!(valid_o && !chain_en_n_o));
            // R4
            idle_zero_chk: assert (!(req_i == '0 && (idx_o != '0 || valid_o)));
        end
    end
endmodule

// File: tb/sim_cascade_prio8.sv
module sim_cascade_prio8;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req = '0;
    logic       en_n = 1'b0;
    logic [2:0] idx;
    logic       vld;
    logic       eo_n;

    int n_cmp  = 0;
    int n_fail = 0;
    bit drive_done = 1'b0;

    typedef struct {
        logic [7:0] req;
        logic       en_n;
        logic [2:0] idx;
        logic       vld;
        logic       eo_n;
        string      tag;
    } item_t;

    item_t exp_q[$];

    cascade_prio8 u0 (
        .req_i        (req),
        .chain_en_n_i (en_n),
        .idx_o        (idx),
        .valid_o      (vld),
        .chain_en_n_o (eo_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: scan from the top line downward.
    function automatic item_t model(input logic [7:0] r, input logic e_n, input string tag);
        item_t it;
        it.req = r; it.en_n = e_n; it.tag = tag;
        it.idx = 3'd0; it.vld = 1'b0;
        if (!e_n) begin
            for (int k = 7; k >= 0; k--) begin
                if (r[k] && !it.vld) begin
                    it.idx = 3'(k);
                    it.vld = 1'b1;
                end
            end
        end
        it.eo_n = !(!e_n && r == 8'd0);
        return it;
    endfunction

    task automatic drive(input logic [7:0] r, input logic e_n, input string tag);
        @(posedge clk);
        #1;
        req  = r;
        en_n = e_n;
        exp_q.push_back(model(r, e_n, tag));
    endtask

    task automatic chk(input string tag, input int act, input int exp, input logic [7:0] r);
        n_cmp++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s req=%b actual=%0d expected=%0d", tag, r, act, exp);
        end
    endtask

    // Monitor: outputs are settled by the falling edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            chk(it.tag, int'(idx), int'(it.idx), it.req);
            chk("R3", int'(vld), int'(it.vld), it.req);
            chk("R7", int'(eo_n), int'(it.eo_n), it.req);
            if (!it.en_n) begin
                chk("R2", int'(idx[2]), int'(it.req[7:4] != 4'd0), it.req);
            end
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // R4: idle state after reset
        drive(8'h00, 1'b0, "R4");
        // R5: single request on line 5
        drive(8'h20, 1'b0, "R5");
        // R1: every pattern with the chain enabled
        for (int p = 0; p < 256; p++) drive(8'(p), 1'b0, "R1");
        // R6: every pattern with the chain disabled
        for (int p = 0; p < 256; p++) drive(8'(p), 1'b1, "R6");
        // R8: upper group busy, lower group swept
        for (int u = 1; u < 16; u++) begin
            for (int l = 0; l < 16; l += 5) drive({4'(u), 4'(l)}, 1'b0, "R8");
        end
        drive(8'h00, 1'b0, "R4");
        @(posedge clk);
        drive_done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!(drive_done && exp_q.size() == 0) && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (cyc >= WATCHDOG) begin
            n_cmp++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
        end
        @(posedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end
endmodule